// File: doc/BRIEF.md
# LIN Break Field Length Meter

This block sits in front of a LIN receiver. It watches the receive line and measures how long the line stays dominant (low) at the start of a frame. It samples the line at a prescaled rate and counts low samples in a 12-bit counter. When the line returns high after a long enough low period, the block raises a break flag. It then follows the synch byte and raises an end-of-synch flag once the byte's last rising edge arrives.

The counter does not wrap. If it runs past its range, the block reports a synch error instead of a break. The same happens when the line stops changing for a full counter range during the synch byte. The prescale select therefore sets the longest break the block can measure. For example, with a 24 MHz clock, select 0 and 19.2 kbit/s, the limit is about 26 bit times.

Software supplies the number of samples per bit, the prescale select and a detection-disable control. It clears each flag with its own strobe. Raising the disable control and dropping it again returns the detector to idle.

Top module: `lin_break_meter`

## Requirements
- R1: After reset all three flags are 0, and detection is enabled while the disable input is 0.
- R2: The line is sampled once every 8 × 2^sel clock cycles, where sel is the prescale select value.
- R3: A low period of at least 11 × bit_len samples sets the break flag on the sample where the line reads high again. A shorter low period leaves the break flag at 0.
- R4: A low period longer than 4095 samples sets the synch-error flag and does not set the break flag. The detector waits for the line to go high before it looks for a new break.
- R5: After a break, the detector counts falling edges of the synch byte (start bit included). It sets the end-of-synch flag on the first rising edge after the fifth falling edge.
- R6: After a break, if 4096 samples pass with no edge on the line, the synch-error flag is set and the end-of-synch flag stays 0.
- R7: While the disable input is 1, no flag is set. Setting it to 1 and back to 0 discards any measurement in progress. A line that is already low when detection is re-enabled does not count as a falling edge.
- R8: Each clear strobe clears only its own flag. In the same cycle, a set of that flag wins over its clear.
- R9: The counter restarts from 1 on each falling edge seen while idle. It counts each further low sample by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | LIN receive line, asynchronous |
| presc_sel_i | input | PSEL_W | Prescale select; sample divide is 8 × 2^sel |
| bit_len_i | input | BLEN_W | Samples per bit time |
| det_off_i | input | 1 | 1 disables detection and reinitialises it |
| clr_brk_i | input | 1 | Clear strobe for the break flag |
| clr_eos_i | input | 1 | Clear strobe for the end-of-synch flag |
| clr_err_i | input | 1 | Clear strobe for the synch-error flag |
| brk_flag_o | output | 1 | Break detected |
| eos_flag_o | output | 1 | End of synch byte seen |
| synch_err_o | output | 1 | Counter overflow or synch timeout |

## Verification
The assertions check several rules on every cycle. The spacing between sample ticks must match the prescale select. No flag may rise while detection is disabled, or in the cycle after. A flag may fall only after its clear strobe. An error may only follow a full counter. The threshold comparison, the overflow after a long low period, the edge count of the synch byte, the synch timeout and the reinitialisation on re-enable depend on whole waveforms. Only the bench's directed scenarios can show them, by driving line patterns with margins around each threshold and reading the flags afterwards.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_SYNC = 2'd2,
    ST_HOLD = 2'd3
  } lbm_state_t;

  localparam int BRK_BITS   = 11;
  localparam int SYNC_FALLS = 5;
  localparam int FLAG_N     = 3;
  localparam int F_BRK      = 0;
  localparam int F_EOS      = 1;
  localparam int F_ERR      = 2;
endpackage

// File: rtl/lbm_sync.sv
module lbm_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/lbm_presc.sv
module lbm_presc #(
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PSEL_W-1:0] sel,
  output logic              tick
);
  localparam int DIV_W = 3 + (1 << PSEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_n, lim;

  always_comb begin
    lim   = DIV_W'((32'd8 << sel) - 32'd1);
    tick  = run && (div_q >= lim);
    if (!run || tick) div_n = '0;
    else              div_n = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end
endmodule

// File: rtl/lbm_ctrl.sv
module lbm_ctrl
  import lbm_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int BLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              rx,
  input  logic [BLEN_W-1:0] bit_len,
  output logic              brk_set,
  output logic              eos_set,
  output logic              err_set,
  output logic [CNT_W-1:0]  cnt
);
  localparam int TW    = BLEN_W + 4;
  localparam int CMP_W = (CNT_W > TW) ? CNT_W : TW;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  lbm_state_t       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [2:0]       fall_q, fall_n;
  logic             line_q, line_n;
  logic [TW-1:0]    thr;
  logic             fall, rise, long_enough;

  always_comb begin
    thr         = TW'(bit_len) * TW'(BRK_BITS);
    long_enough = CMP_W'(cnt_q) >= CMP_W'(thr);
    fall        = line_q & ~rx;
    rise        = ~line_q & rx;
    st_n    = st_q;
    cnt_n   = cnt_q;
    fall_n  = fall_q;
    line_n  = line_q;
    brk_set = 1'b0;
    eos_set = 1'b0;
    err_set = 1'b0;
    if (!run) begin
      st_n   = ST_IDLE;
      cnt_n  = '0;
      fall_n = '0;
      line_n = rx;
    end else if (tick) begin
      line_n = rx;
      unique case (st_q)
        ST_IDLE: begin
          if (fall) begin
            cnt_n = CNT_W'(1);
            st_n  = ST_LOW;
          end
        end
        ST_LOW: begin
          if (!rx) begin
            if (cnt_q == CNT_MAX) begin
              err_set = 1'b1;
              cnt_n   = '0;
              st_n    = ST_HOLD;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end else if (long_enough) begin
            brk_set = 1'b1;
            cnt_n   = '0;
            fall_n  = '0;
            st_n    = ST_SYNC;
          end else begin
            cnt_n = '0;
            st_n  = ST_IDLE;
          end
        end
        ST_SYNC: begin
          if (fall) begin
            fall_n = (fall_q == 3'd7) ? fall_q : fall_q + 1'b1;
            cnt_n  = '0;
          end else if (rise && fall_q == 3'(SYNC_FALLS)) begin
            eos_set = 1'b1;
            cnt_n   = '0;
            st_n    = ST_IDLE;
          end else if (rise) begin
            cnt_n = '0;
          end else if (cnt_q == CNT_MAX) begin
            err_set = 1'b1;
            cnt_n   = '0;
            st_n    = ST_HOLD;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: begin
          if (rx) st_n = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      fall_q <= '0;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      fall_q <= fall_n;
      line_q <= line_n;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lbm_flag.sv
module lbm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_n, q_r;

  always_comb begin
    if (set)      q_n = 1'b1;
    else if (clr) q_n = 1'b0;
    else          q_n = q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_n;
  end

  assign q = q_r;
endmodule

// File: rtl/lin_break_meter.sv
module lin_break_meter
  import lbm_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int PSEL_W = 2,
  parameter int BLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic [PSEL_W-1:0] presc_sel_i,
  input  logic [BLEN_W-1:0] bit_len_i,
  input  logic              det_off_i,
  input  logic              clr_brk_i,
  input  logic              clr_eos_i,
  input  logic              clr_err_i,
  output logic              brk_flag_o,
  output logic              eos_flag_o,
  output logic              synch_err_o
);
  logic              rx_s, tick, run;
  logic [CNT_W-1:0]  cnt_w;
  logic [FLAG_N-1:0] set_v, clr_v, flag_v;

  assign run = ~det_off_i;

  lbm_sync u_sync (.clk(clk), .rst_n(rst_n), .d(rxd_i), .q(rx_s));

  lbm_presc #(.PSEL_W(PSEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(presc_sel_i), .tick(tick)
  );

  lbm_ctrl #(.CNT_W(CNT_W), .BLEN_W(BLEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .rx(rx_s),
    .bit_len(bit_len_i),
    .brk_set(set_v[F_BRK]), .eos_set(set_v[F_EOS]), .err_set(set_v[F_ERR]),
    .cnt(cnt_w)
  );

  assign clr_v[F_BRK] = clr_brk_i;
  assign clr_v[F_EOS] = clr_eos_i;
  assign clr_v[F_ERR] = clr_err_i;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    lbm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(set_v[g]), .clr(clr_v[g]), .q(flag_v[g])
    );
  end

  assign brk_flag_o  = flag_v[F_BRK];
  assign eos_flag_o  = flag_v[F_EOS];
  assign synch_err_o = flag_v[F_ERR];
endmodule

// File: rtl/lbm_checker.sv
module lbm_checker #(
  parameter int CNT_W  = 12,
  parameter int PSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [PSEL_W-1:0] sel,
  input logic              det_off,
  input logic [CNT_W-1:0]  cnt,
  input logic              brk,
  input logic              eos,
  input logic              err,
  input logic              clr_brk,
  input logic              clr_eos,
  input logic              clr_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0]        gap_q;
  logic              seen_q;
  logic [PSEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      sel_q <= sel;
      if (det_off || sel != sel_q) begin
        seen_q <= 1'b0;
        gap_q  <= '0;
      end else if (tick) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_q && sel == sel_q && !det_off) |-> (32'(gap_q) + 32'd1 == (32'd8 << sel)));

  // R7
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_off |=> (!$rose(brk) && !$rose(eos) && !$rose(err)));

  // R3
  brk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> !$past(det_off));

  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(cnt) == CNT_MAX));

  // R8
  brk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk) |-> $past(clr_brk));

  // R8
  eos_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eos) |-> $past(clr_eos));

  // R8
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(clr_err));
endmodule

bind lin_break_meter lbm_checker #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sel(presc_sel_i), .det_off(det_off_i),
  .cnt(cnt_w), .brk(brk_flag_o), .eos(eos_flag_o), .err(synch_err_o),
  .clr_brk(clr_brk_i), .clr_eos(clr_eos_i), .clr_err(clr_err_i)
);

// File: tb/lin_break_meter_bench.sv
`timescale 1ns/1ps
module lin_break_meter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rxd;
  logic [1:0] sel;
  logic [7:0] blen;
  logic       doff, cb, ce, cr;
  logic       brk, eos, err;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  localparam int SMP = 8;

  always #2.5 clk = ~clk;

  lin_break_meter u_lin_break_meter (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .presc_sel_i(sel), .bit_len_i(blen),
    .det_off_i(doff), .clr_brk_i(cb), .clr_eos_i(ce), .clr_err_i(cr),
    .brk_flag_o(brk), .eos_flag_o(eos), .synch_err_o(err)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send_low(input int clks);
    rxd = 1'b0;
    wait_clk(clks);
    rxd = 1'b1;
  endtask

  task automatic send_sync(input int bclk);
    logic [9:0] fr = {1'b1, 8'h55, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd = fr[i];
      wait_clk(bclk);
    end
    rxd = 1'b1;
  endtask

  task automatic reinit();
    doff = 1'b1;
    wait_clk(20);
    doff = 1'b0;
    wait_clk(20);
  endtask

  task automatic pulse_clr(input int which);
    if (which == 0) cb = 1'b1;
    if (which == 1) ce = 1'b1;
    if (which == 2) cr = 1'b1;
    wait_clk(1);
    cb = 1'b0; ce = 1'b0; cr = 1'b0;
    wait_clk(2);
  endtask

  task automatic t_reset();
    chk("R1 brk after reset", brk, 1'b0);
    chk("R1 eos after reset", eos, 1'b0);
    chk("R1 err after reset", err, 1'b0);
  endtask

  task automatic t_short();
    send_low(90 * SMP);
    wait_clk(100);
    chk("R3 short low no break", brk, 1'b0);
    chk("R9 short low no error", err, 1'b0);
  endtask

  task automatic t_full();
    send_low(130 * SMP);
    wait_clk(20 * SMP);
    chk("R3 long low sets break", brk, 1'b1);
    send_sync(10 * SMP);
    wait_clk(40);
    chk("R5 end of synch", eos, 1'b1);
    chk("R5 no error on synch", err, 1'b0);
    pulse_clr(0);
    chk("R8 break cleared", brk, 1'b0);
    chk("R8 eos untouched by break clear", eos, 1'b1);
    pulse_clr(1);
    chk("R8 eos cleared", eos, 1'b0);
  endtask

  task automatic t_presc();
    sel = 2'd1;
    wait_clk(40);
    send_low(130 * SMP);
    wait_clk(300);
    chk("R2 half rate too short", brk, 1'b0);
    send_low(130 * 2 * SMP);
    wait_clk(200);
    chk("R2 half rate long enough", brk, 1'b1);
    reinit();
    pulse_clr(0);
    sel = 2'd0;
    wait_clk(40);
  endtask

  task automatic t_disable();
    rxd = 1'b0;
    wait_clk(60 * SMP);
    doff = 1'b1;
    wait_clk(10);
    doff = 1'b0;
    wait_clk(80 * SMP);
    rxd = 1'b1;
    wait_clk(200);
    chk("R7 toggle discards break", brk, 1'b0);
    doff = 1'b1;
    send_low(130 * SMP);
    wait_clk(100);
    chk("R7 disabled no break", brk, 1'b0);
    doff = 1'b0;
    wait_clk(40);
  endtask

  task automatic t_overflow();
    send_low(4120 * SMP);
    wait_clk(100);
    chk("R4 overflow error", err, 1'b1);
    chk("R4 overflow no break", brk, 1'b0);
    pulse_clr(2);
    chk("R8 error cleared", err, 1'b0);
  endtask

  task automatic t_timeout();
    send_low(130 * SMP);
    wait_clk(100);
    chk("R6 break before timeout", brk, 1'b1);
    wait_clk(4150 * SMP);
    chk("R6 synch timeout error", err, 1'b1);
    chk("R6 no eos on timeout", eos, 1'b0);
    pulse_clr(0);
    pulse_clr(2);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; rxd = 1'b1; sel = 2'd0; blen = 8'd10;
    doff = 1'b0; cb = 1'b0; ce = 1'b0; cr = 1'b0;
    wait_clk(5);
    t_reset();
    rst_n = 1'b1;
    wait_clk(20);
    t_reset();
    t_short();
    t_full();
    t_presc();
    t_disable();
    t_overflow();
    t_timeout();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end
endmodule